// File: doc/BRIEF.md
# VEX Prefix Decoder

This block is one stage of an x86 instruction field decoder. It takes the instruction stream one byte per accepted valid/ready beat, starting at the first byte after any legacy and REX prefixes. It recognises the two vector-extension escape bytes: C5 starts the short form and C4 starts the long form. It unpacks the payload bytes that follow and folds them into REX-style register extension bits, a vector length bit, a source register specifier, an implied legacy prefix and an opcode map. It then captures the opcode byte and raises `done` for one cycle, with the decoded record held on the outputs.

Outside 64-bit mode, C4 and C5 are also legal one-byte opcodes that load a far pointer. Their ModRM byte can never use the register form (mod = 11). So when the byte after the escape has mod other than 11, the block drops the vector interpretation. It reports the escape byte as a one-byte opcode and hands that next byte on as ModRM. A first byte that is neither escape is reported as a plain one-byte opcode. Parsing of ModRM, SIB, displacement and immediates is left to later stages.

The state machine has five states:

- `S_IDLE` waits for the first byte.
- `S_V2_PAY` expects the short-form payload.
- `S_V3_PAY1` expects the first long-form payload byte.
- `S_V3_PAY2` expects the second long-form payload byte.
- `S_OPCODE` expects the opcode byte.

Its transitions are:

- `S_IDLE` goes to `S_V2_PAY` on C5, to `S_V3_PAY1` on C4, and stays in `S_IDLE` with done on any other byte.
- `S_V2_PAY` goes to `S_OPCODE`, or back to `S_IDLE` with done on a fallback.
- `S_V3_PAY1` goes to `S_V3_PAY2`, or back to `S_IDLE` with done on a fallback or a reserved map.
- `S_V3_PAY2` goes to `S_OPCODE`.
- `S_OPCODE` goes back to `S_IDLE` with done.

Top module: `vex_prefix_decoder`

## Requirements
- R1: A synchronous active-low reset returns the machine to idle, clears every decoded output to zero and holds `done` low; `in_ready` is low during reset and high otherwise.
- R2: After C5, the single payload byte carries R in bit 7, vvvv in bits 6:3, L in bit 2 and pp in bits 1:0. The record shows `vex_present`=1, map 0F, `rex_x`=`rex_b`=0, `rex_w`=0, and the byte after the payload as the opcode.
- R3: R, X, B and vvvv are stored complemented in the payload: `rex_r`, `rex_x`, `rex_b` and `vvvv` output the bitwise inverse of the received bits, while L and W are passed through unchanged.
- R4: pp selects the implied prefix: 00 none, 01 `pfx_opsize`, 10 `pfx_rep`, 11 `pfx_repne`; at most one of the three is ever set.
- R5: After C4, the first payload byte carries R, X, B in bits 7, 6, 5 and the map select in bits 4:0. The second carries W in bit 7, vvvv in 6:3, L in 2 and pp in 1:0. `op_map` reports map select 1, 2, 3 as codes 1 (0F), 2 (0F38) and 3 (0F3A), and code 0 means the one-byte map.
- R6: A map select other than 1, 2 or 3 ends the instruction on that byte with map 0F and opcode 0B (undefined). No further byte belongs to it, so the next byte starts a new instruction.
- R7: With `long_mode` low, if the byte after C4 or C5 has bits 7:6 not equal to 11, the record shows `vex_present`=0, map 0, opcode equal to the escape byte, `modrm_fwd`=1 and `modrm_byte` equal to that byte; otherwise `modrm_fwd` is 0.
- R8: With `long_mode` high, the byte after C4 or C5 is always treated as a payload byte, whatever its top two bits.
- R9: A first byte other than C4 or C5 completes at once as a one-byte-map opcode with `vex_present`=0.
- R10: A byte is consumed only on a cycle with `in_valid` and `in_ready` both high, and idle cycles do not change the state. `done` is high for exactly the one cycle after the last byte of an instruction is accepted, and the record stays stable until the next instruction's first byte is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| long_mode | input | 1 | High when the processor is in 64-bit mode |
| in_valid | input | 1 | Instruction byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block can accept a byte |
| done | output | 1 | One-cycle pulse: record below is complete |
| vex_present | output | 1 | Instruction used a vector-extension prefix |
| rex_r | output | 1 | ModRM.reg extension |
| rex_x | output | 1 | SIB.index extension |
| rex_b | output | 1 | ModRM.rm / base extension |
| rex_w | output | 1 | Operand width bit |
| vec_len | output | 1 | Vector length bit L |
| vvvv | output | 4 | Extra source register number |
| pfx_opsize | output | 1 | Implied operand-size prefix |
| pfx_rep | output | 1 | Implied REP prefix |
| pfx_repne | output | 1 | Implied REPNE prefix |
| op_map | output | 2 | 0 one-byte, 1 0F, 2 0F38, 3 0F3A |
| opcode | output | 8 | Opcode byte within `op_map` |
| modrm_fwd | output | 1 | `modrm_byte` was consumed and is the ModRM byte |
| modrm_byte | output | 8 | Forwarded ModRM byte on fallback |

## Verification
The assertions watch, on every cycle, the invariants of the record and of the handshake. They check that the implied prefix flags stay mutually exclusive and that `done` only appears with the machine back in idle. They also check that a fallback record always has the one-byte shape, that no fallback happens in 64-bit mode, that a reserved map yields the undefined opcode on the very next cycle, and that idle input cycles leave the state unchanged. The bit-level decoding can only be shown by the bench's scenarios against its reference model: the payload positions, the inversions, every pp and map value, the fallback boundary at mod = 11, and the fact that the byte after a reserved map starts a fresh instruction.

// File: rtl/vexdec_pkg.sv
package vexdec_pkg;

    localparam int BYTE_W  = 8;
    localparam int VVVV_W  = 4;
    localparam int MSEL_W  = 5;
    localparam int PP_W    = 2;

    localparam logic [BYTE_W-1:0] ESC_LONG  = 8'hC4;
    localparam logic [BYTE_W-1:0] ESC_SHORT = 8'hC5;
    localparam logic [BYTE_W-1:0] UD_OPCODE = 8'h0B;

    typedef enum logic [2:0] {
        S_IDLE,
        S_V2_PAY,
        S_V3_PAY1,
        S_V3_PAY2,
        S_OPCODE
    } vex_state_e;

    typedef enum logic [1:0] {
        MAP_LEGACY = 2'd0,
        MAP_0F     = 2'd1,
        MAP_0F38   = 2'd2,
        MAP_0F3A   = 2'd3
    } opmap_e;

    // Every candidate field a payload byte could supply, already un-inverted.
    typedef struct packed {
        logic              rex_r;
        logic              rex_x;
        logic              rex_b;
        logic              rex_w;
        logic              vlen;
        logic [VVVV_W-1:0] vvvv;
        logic [PP_W-1:0]   pp;
        opmap_e            map;
        logic              map_ok;
        logic              reg_form;
    } payload_t;

    // Decoded instruction record held on the outputs.
    typedef struct packed {
        logic              vex_present;
        logic              rex_r;
        logic              rex_x;
        logic              rex_b;
        logic              rex_w;
        logic              vlen;
        logic [VVVV_W-1:0] vvvv;
        logic              pfx_opsize;
        logic              pfx_rep;
        logic              pfx_repne;
        opmap_e            map;
        logic [BYTE_W-1:0] opcode;
        logic              modrm_fwd;
        logic [BYTE_W-1:0] modrm;
    } vex_rec_t;

endpackage

// File: rtl/vexdec_payload.sv
module vexdec_payload
    import vexdec_pkg::*;
(
    input  logic [BYTE_W-1:0] pay_byte,
    output payload_t          fields
);

    localparam int TOP = BYTE_W - 1;

    always_comb begin
        fields.rex_r    = ~pay_byte[TOP];
        fields.rex_x    = ~pay_byte[TOP-1];
        fields.rex_b    = ~pay_byte[TOP-2];
        fields.rex_w    =  pay_byte[TOP];
        fields.vvvv     = ~pay_byte[TOP-1 -: VVVV_W];
        fields.vlen     =  pay_byte[PP_W];
        fields.pp       =  pay_byte[PP_W-1:0];
        fields.reg_form = &pay_byte[TOP -: 2];
        fields.map_ok   = 1'b1;
        unique case (pay_byte[MSEL_W-1:0])
            5'd1:    fields.map = MAP_0F;
            5'd2:    fields.map = MAP_0F38;
            5'd3:    fields.map = MAP_0F3A;
            default: begin
                fields.map    = MAP_0F;
                fields.map_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vexdec_pp_decode.sv
module vexdec_pp_decode
    import vexdec_pkg::*;
(
    input  logic [PP_W-1:0] pp,
    output logic            opsize,
    output logic            rep,
    output logic            repne
);

    always_comb begin
        opsize = 1'b0;
        rep    = 1'b0;
        repne  = 1'b0;
        unique case (pp)
            2'b01:   opsize = 1'b1;
            2'b10:   rep    = 1'b1;
            2'b11:   repne  = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/vex_prefix_decoder.sv
module vex_prefix_decoder
    import vexdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              long_mode,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              done,
    output logic              vex_present,
    output logic              rex_r,
    output logic              rex_x,
    output logic              rex_b,
    output logic              rex_w,
    output logic              vec_len,
    output logic [VVVV_W-1:0] vvvv,
    output logic              pfx_opsize,
    output logic              pfx_rep,
    output logic              pfx_repne,
    output logic [1:0]        op_map,
    output logic [BYTE_W-1:0] opcode,
    output logic              modrm_fwd,
    output logic [BYTE_W-1:0] modrm_byte
);

    vex_state_e state_q, state_d;
    vex_rec_t   rec_q, rec_d;
    logic       done_q, done_d;
    logic       ready_q;
    payload_t   pl;
    logic       pp_opsize, pp_rep, pp_repne;
    logic       accept;
    logic       fallback;

    vexdec_payload u_payload (
        .pay_byte (in_byte),
        .fields   (pl)
    );

    vexdec_pp_decode u_pp (
        .pp     (pl.pp),
        .opsize (pp_opsize),
        .rep    (pp_rep),
        .repne  (pp_repne)
    );

    assign accept   = in_valid && in_ready;
    assign fallback = !long_mode && !pl.reg_form;

    // Next state and next record.
    always_comb begin
        state_d = state_q;
        rec_d   = rec_q;
        done_d  = 1'b0;
        if (accept) begin
            unique case (state_q)
                S_IDLE: begin
                    rec_d = '0;
                    if (in_byte == ESC_SHORT) begin
                        rec_d.vex_present = 1'b1;
                        state_d           = S_V2_PAY;
                    end else if (in_byte == ESC_LONG) begin
                        rec_d.vex_present = 1'b1;
                        state_d           = S_V3_PAY1;
                    end else begin
                        rec_d.opcode = in_byte;
                        rec_d.map    = MAP_LEGACY;
                        done_d       = 1'b1;
                    end
                end
                S_V2_PAY: begin
                    if (fallback) begin
                        rec_d.vex_present = 1'b0;
                        rec_d.opcode      = ESC_SHORT;
                        rec_d.map         = MAP_LEGACY;
                        rec_d.modrm_fwd   = 1'b1;
                        rec_d.modrm       = in_byte;
                        done_d            = 1'b1;
                        state_d           = S_IDLE;
                    end else begin
                        rec_d.rex_r      = pl.rex_r;
                        rec_d.vvvv       = pl.vvvv;
                        rec_d.vlen       = pl.vlen;
                        rec_d.pfx_opsize = pp_opsize;
                        rec_d.pfx_rep    = pp_rep;
                        rec_d.pfx_repne  = pp_repne;
                        rec_d.map        = MAP_0F;
                        state_d          = S_OPCODE;
                    end
                end
                S_V3_PAY1: begin
                    if (fallback) begin
                        rec_d.vex_present = 1'b0;
                        rec_d.opcode      = ESC_LONG;
                        rec_d.map         = MAP_LEGACY;
                        rec_d.modrm_fwd   = 1'b1;
                        rec_d.modrm       = in_byte;
                        done_d            = 1'b1;
                        state_d           = S_IDLE;
                    end else begin
                        rec_d.rex_r = pl.rex_r;
                        rec_d.rex_x = pl.rex_x;
                        rec_d.rex_b = pl.rex_b;
                        rec_d.map   = pl.map;
                        if (pl.map_ok) begin
                            state_d = S_V3_PAY2;
                        end else begin
                            rec_d.opcode = UD_OPCODE;
                            done_d       = 1'b1;
                            state_d      = S_IDLE;
                        end
                    end
                end
                S_V3_PAY2: begin
                    rec_d.rex_w      = pl.rex_w;
                    rec_d.vvvv       = pl.vvvv;
                    rec_d.vlen       = pl.vlen;
                    rec_d.pfx_opsize = pp_opsize;
                    rec_d.pfx_rep    = pp_rep;
                    rec_d.pfx_repne  = pp_repne;
                    state_d          = S_OPCODE;
                end
                S_OPCODE: begin
                    rec_d.opcode = in_byte;
                    done_d       = 1'b1;
                    state_d      = S_IDLE;
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q   <= '0;
            done_q  <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            rec_q   <= rec_d;
            done_q  <= done_d;
            ready_q <= 1'b1;
        end
    end

    assign in_ready    = ready_q && rst_n;
    assign done        = done_q;
    assign vex_present = rec_q.vex_present;
    assign rex_r       = rec_q.rex_r;
    assign rex_x       = rec_q.rex_x;
    assign rex_b       = rec_q.rex_b;
    assign rex_w       = rec_q.rex_w;
    assign vec_len     = rec_q.vlen;
    assign vvvv        = rec_q.vvvv;
    assign pfx_opsize  = rec_q.pfx_opsize;
    assign pfx_rep     = rec_q.pfx_rep;
    assign pfx_repne   = rec_q.pfx_repne;
    assign op_map      = rec_q.map;
    assign opcode      = rec_q.opcode;
    assign modrm_fwd   = rec_q.modrm_fwd;
    assign modrm_byte  = rec_q.modrm;

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!done_q && !rec_q.vex_present && rec_q.opcode == '0)); // R1
    AST_PFX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({pfx_opsize, pfx_rep, pfx_repne})); // R4
    AST_RESERVED_UD: assert property (@(posedge clk) disable iff (!rst_n) (accept && state_q == S_V3_PAY1 && (long_mode || in_byte[7:6] == 2'b11) && in_byte[4:0] != 5'd1 && in_byte[4:0] != 5'd2 && in_byte[4:0] != 5'd3) |=> (done && opcode == UD_OPCODE && op_map == MAP_0F)); // R6
    AST_FALLBACK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n) (done && modrm_fwd) |-> (!vex_present && op_map == MAP_LEGACY && (opcode == ESC_LONG || opcode == ESC_SHORT))); // R7
    AST_LONG_NO_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n) (done && $past(long_mode)) |-> !modrm_fwd); // R8
    AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> state_q == S_IDLE); // R10
    AST_IDLE_BEAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !accept |=> ($stable(state_q) && !done)); // R10

endmodule

// File: tb/test_vex_prefix_decoder.sv
`timescale 1ns/1ps
module test_vex_prefix_decoder;

    typedef logic [7:0] bq_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       long_mode = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready, done, vex_present, rex_r, rex_x, rex_b, rex_w, vec_len;
    logic [3:0] vvvv;
    logic       pfx_opsize, pfx_rep, pfx_repne, modrm_fwd;
    logic [1:0] op_map;
    logic [7:0] opcode, modrm_byte;
    logic [31:0] got;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    vex_prefix_decoder i_vex_prefix_decoder (
        .clk (clk), .rst_n (rst_n), .long_mode (long_mode),
        .in_valid (in_valid), .in_byte (in_byte), .in_ready (in_ready),
        .done (done), .vex_present (vex_present),
        .rex_r (rex_r), .rex_x (rex_x), .rex_b (rex_b), .rex_w (rex_w),
        .vec_len (vec_len), .vvvv (vvvv),
        .pfx_opsize (pfx_opsize), .pfx_rep (pfx_rep), .pfx_repne (pfx_repne),
        .op_map (op_map), .opcode (opcode),
        .modrm_fwd (modrm_fwd), .modrm_byte (modrm_byte)
    );

    assign got = {vex_present, rex_r, rex_x, rex_b, rex_w, vec_len, vvvv,
                  pfx_opsize, pfx_rep, pfx_repne, op_map, opcode, modrm_fwd, modrm_byte};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Behavioural reference: reads the byte list as an instruction.
    function automatic logic [31:0] model(input bq_t q, input bit lm);
        bit vex = 0, r = 0, x = 0, b = 0, w = 0, l = 0, fwd = 0;
        logic [3:0] v = 4'h0;
        logic [1:0] mp = 2'd0, pp = 2'd0;
        logic [7:0] opc = 8'h00, mr = 8'h00;
        int msel;
        if (q[0] == 8'hC5 || q[0] == 8'hC4) begin
            if (!lm && q[1][7:6] != 2'b11) begin
                opc = q[0]; fwd = 1; mr = q[1];
            end else if (q[0] == 8'hC5) begin
                vex = 1; r = !q[1][7]; v = ~q[1][6:3]; l = q[1][2]; pp = q[1][1:0];
                mp = 2'd1; opc = q[2];
            end else begin
                vex = 1; r = !q[1][7]; x = !q[1][6]; b = !q[1][5];
                msel = int'(q[1][4:0]);
                if (msel >= 1 && msel <= 3) begin
                    mp = 2'(msel);
                    w = q[2][7]; v = ~q[2][6:3]; l = q[2][2]; pp = q[2][1:0];
                    opc = q[3];
                end else begin
                    mp = 2'd1; opc = 8'h0B;
                end
            end
        end else begin
            opc = q[0];
        end
        return {vex, r, x, b, w, l, v, pp == 2'd1, pp == 2'd2, pp == 2'd3, mp, opc, fwd, mr};
    endfunction

    // Send one instruction; compare done every clock and the record at done.
    task automatic run(input bq_t q, input bit lm, input string req, input bit gaps);
        logic [31:0] exp;
        exp = model(q, lm);
        long_mode = lm;
        foreach (q[i]) begin
            @(negedge clk);
            if (i > 0) chk({req, " R10 no done mid-instruction"}, {31'd0, done}, 32'd0);
            in_valid = 1'b1;
            in_byte  = q[i];
            if (gaps && i > 0) begin
                in_valid = 1'b0;
                in_byte  = 8'hC4;
                @(negedge clk);
                chk({req, " R10 idle beat"}, {31'd0, done}, 32'd0);
                in_valid = 1'b1;
                in_byte  = q[i];
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'h00;
        chk({req, " R10 done pulse"}, {31'd0, done}, 32'd1);
        chk(req, got, exp);
        @(negedge clk);
        chk({req, " R10 done one cycle"}, {31'd0, done}, 32'd0);
        chk({req, " R10 record held"}, got, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset record", got, 32'd0);
        chk("R1 ready low in reset", {30'd0, in_ready, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {31'd0, in_ready}, 32'd1);

        // R2 / R4: short form, every pp value, assorted R/vvvv/L.
        for (int p = 0; p < 4; p++) begin
            bq_t q;
            q = '{8'hC5, {p[0] ? 1'b1 : 1'b0, 4'(p * 5 + 1), p[1] ? 1'b1 : 1'b0, 2'(p)}, 8'(8'h58 + p)};
            run(q, 1'b1, "R2 R4 short form", 1'b0);
        end
        // R3: all-zero payload gives all-ones after inversion.
        run('{8'hC5, 8'h00, 8'h10}, 1'b1, "R3 inversion short", 1'b0);
        // R5: long form, each valid map, W both ways.
        run('{8'hC4, 8'hE1, 8'hFD, 8'h6F}, 1'b1, "R5 map 0F", 1'b0);
        run('{8'hC4, 8'h02, 8'h79, 8'h18}, 1'b1, "R5 R3 map 0F38", 1'b0);
        run('{8'hC4, 8'h43, 8'h86, 8'h0F}, 1'b1, "R5 R4 map 0F3A", 1'b0);
        run('{8'hC4, 8'hA3, 8'h4F, 8'h4A}, 1'b1, "R5 gaps", 1'b1);
        // R6: reserved maps, then the next byte is its own instruction.
        run('{8'hC4, 8'hE0}, 1'b1, "R6 map 0", 1'b0);
        run('{8'h90}, 1'b1, "R6 R9 next byte fresh", 1'b0);
        run('{8'hC4, 8'h64}, 1'b1, "R6 map 4", 1'b0);
        run('{8'hC4, 8'hFF}, 1'b1, "R6 map 31", 1'b0);
        // R7: fallback outside 64-bit mode.
        run('{8'hC4, 8'h05}, 1'b0, "R7 les fallback", 1'b0);
        run('{8'hC5, 8'hBF}, 1'b0, "R7 lds fallback", 1'b0);
        run('{8'hC5, 8'hC8, 8'h77}, 1'b0, "R7 reg form decodes", 1'b0);
        run('{8'hC4, 8'hC1, 8'h05, 8'h58}, 1'b0, "R7 long form reg", 1'b0);
        // R8: same bytes in 64-bit mode stay vector prefixes.
        run('{8'hC5, 8'h3C, 8'h28}, 1'b1, "R8 short no fallback", 1'b0);
        run('{8'hC4, 8'h01, 8'h00, 8'hAA}, 1'b1, "R8 long no fallback", 1'b0);
        run('{8'hC4, 8'h05}, 1'b1, "R8 R6 reserved not les", 1'b0);
        // R9: plain opcode byte.
        run('{8'h0F}, 1'b0, "R9 plain opcode", 1'b0);

        // R1: reset in the middle of an instruction.
        @(negedge clk);
        long_mode = 1'b1;
        in_valid  = 1'b1;
        in_byte   = 8'hC4;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 mid-instruction before reset", {31'd0, vex_present}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mid-instruction reset", got, 32'd0);
        run('{8'h01}, 1'b1, "R1 R9 after reset", 1'b0);

        finish_run();
    end

endmodule